// File: doc/BRIEF.md
# Core-to-Bank Request Crossbar

This block routes requests from eight core-side ports to four cache-bank ports. Each request has a physical address and a payload word. The bank is picked by the cache-block interleave field of the address. The request then waits in a small queue that belongs only to its (source, bank) pair. A full queue therefore holds back only traffic for that one pair. The same core can keep sending to the other banks.

Each bank port has a round-robin arbiter over the eight queues that feed it. The bank port presents the winner together with the index of the source that sent it.

Both the core side and the bank side use valid/ready handshakes. A transfer takes place on a rising clock edge when valid and ready are both high.

Back-pressure rules:
- Source ready depends on that source's address, because the address selects the queue. Ready is low only when the selected queue is full and is not being drained in the same cycle.
- Once a bank port raises valid, it holds valid and all of its fields stable until the bank takes the request.
- The core count, bank count, queue depth, address width and payload width are parameters.

Top module: `core_bank_xbar`

## Requirements
- R1: A request accepted from source s with address bits [7:6] equal to b (64-byte blocks, four banks) appears on bank port b. Its address and payload are unchanged and `dst_src` equals s. It is visible on the bank port no earlier than the cycle after acceptance.
- R2: Each (source, bank) queue holds exactly two requests. With the bank stalled, a source is accepted twice to that bank, and its ready is low for a third request to the same bank.
- R3: A source whose queue to one bank is full is still accepted, in the same cycle, for a request to a different bank.
- R4: Requests from one source to one bank leave the bank port in the order they were accepted.
- R5: Each bank arbiter grants round-robin. After a grant to source k, the search for the next grant starts at source k+1, wrapping from 7 to 0.
- R6: While `dst_valid` is high and `dst_ready` is low, the next cycle shows `dst_valid` high with the same `dst_src`, address and payload. This holds even if a source with higher priority becomes pending.
- R7: A full queue whose bank accepts its head in the current cycle also accepts a new request in that cycle, so source ready is high.
- R8: After reset all queues are empty, so every `dst_valid` is low and every source ready is high. Every arbiter pointer is at source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | NUM_SRC | Per-source request valid |
| src_addr | input | NUM_SRC x ADDR_W | Per-source physical address |
| src_data | input | NUM_SRC x DATA_W | Per-source payload |
| src_ready | output | NUM_SRC | Per-source accept; depends on that source's address |
| dst_valid | output | NUM_DST | Per-bank request valid |
| dst_addr | output | NUM_DST x ADDR_W | Address of the presented request |
| dst_data | output | NUM_DST x DATA_W | Payload of the presented request |
| dst_src | output | NUM_DST x $clog2(NUM_SRC) | Index of the originating source |
| dst_ready | input | NUM_DST | Per-bank accept |

## Verification
The embedded checks assume only that reset is applied before traffic starts. They make no assumption about `dst_ready`: a bank may stall for any number of cycles. This is why the bench holds banks off for long runs, to fill queues and engage the output hold.

Address and payload are assumed settled before each edge. The stimulus therefore changes every input shortly after a rising edge and reads results near the falling edge. Sources are never required to keep a request once offered; the bench withdraws requests freely, and the checks do not depend on source-side stability.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Next position after idx in a ring of n entries.
  function automatic int ring_next(input int idx, input int n);
    return (idx >= n - 1) ? 0 : idx + 1;
  endfunction

  // Width of an index into n entries (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xbar_pair_fifo.sv
module xbar_pair_fifo
  import xbar_pkg::*;
#(
  parameter int W     = 104,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         full
);
  localparam int PTR_W = idx_width(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign not_empty = (count != '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);

endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
  import xbar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            req,
  input  logic                    advance,
  input  logic [idx_width(N)-1:0] advance_idx,
  output logic [N-1:0]            gnt,
  output logic [idx_width(N)-1:0] gnt_idx
);
  localparam int IW = idx_width(N);

  logic [IW-1:0] ptr;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && req[(int'(ptr) + i) % N]) begin
        found                       = 1'b1;
        gnt[(int'(ptr) + i) % N]    = 1'b1;
        gnt_idx                     = IW'((int'(ptr) + i) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= IW'(ring_next(int'(advance_idx), N));
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R5
  gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/xbar_bank_port.sv
module xbar_bank_port
  import xbar_pkg::*;
#(
  parameter int NS = 8,
  parameter int W  = 104
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NS-1:0]            req,
  input  logic [NS-1:0][W-1:0]     heads,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [W-1:0]             out_payload,
  output logic [idx_width(NS)-1:0] out_src,
  output logic [NS-1:0]            pop
);
  localparam int SW = idx_width(NS);

  logic [NS-1:0] arb_gnt;
  logic [SW-1:0] arb_idx;
  logic          held;
  logic [SW-1:0] held_idx;
  logic [SW-1:0] sel_idx;
  logic          xfer;

  xbar_rr_arb #(.N(NS)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .advance     (xfer),
    .advance_idx (sel_idx),
    .gnt         (arb_gnt),
    .gnt_idx     (arb_idx)
  );

  // A stalled offer keeps its source until taken.
  assign sel_idx     = held ? held_idx : arb_idx;
  assign out_valid   = held || (|req);
  assign out_payload = heads[sel_idx];
  assign out_src     = sel_idx;
  assign xfer        = out_valid && out_ready;

  always_comb begin
    pop = '0;
    if (xfer) pop[sel_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_idx <= '0;
    end else begin
      held     <= out_valid && !out_ready;
      held_idx <= sel_idx;
    end
  end

  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_src) && $stable(out_payload)));

endmodule

// File: rtl/core_bank_xbar.sv
module core_bank_xbar
  import xbar_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_DST = 4,
  parameter int DEPTH   = 2,
  parameter int ADDR_W  = 40,
  parameter int DATA_W  = 64,
  parameter int BLK_OFF = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_SRC-1:0]                     src_valid,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0]         src_addr,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]         src_data,
  output logic [NUM_SRC-1:0]                     src_ready,
  output logic [NUM_DST-1:0]                     dst_valid,
  output logic [NUM_DST-1:0][ADDR_W-1:0]         dst_addr,
  output logic [NUM_DST-1:0][DATA_W-1:0]         dst_data,
  output logic [NUM_DST-1:0][idx_width(NUM_SRC)-1:0] dst_src,
  input  logic [NUM_DST-1:0]                     dst_ready
);
  localparam int SEL_W = idx_width(NUM_DST);
  localparam int SW    = idx_width(NUM_SRC);
  localparam int PW    = ADDR_W + DATA_W;

  logic [NUM_SRC-1:0][SEL_W-1:0]         bank_sel;
  logic [NUM_SRC-1:0][NUM_DST-1:0]       q_push, q_pop, q_full, q_nonempty;
  logic [NUM_SRC-1:0][NUM_DST-1:0][PW-1:0] q_head;
  logic [NUM_DST-1:0][NUM_SRC-1:0]       b_req, b_pop;
  logic [NUM_DST-1:0][NUM_SRC-1:0][PW-1:0] b_head;
  logic [NUM_DST-1:0][PW-1:0]            b_payload;

  // Bank choice from the block-interleave field; ready looks at that queue only.
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      bank_sel[s]  = src_addr[s][BLK_OFF +: SEL_W];
      src_ready[s] = !q_full[s][bank_sel[s]] || b_pop[bank_sel[s]][s];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
      assign q_push[s][d] = src_valid[s] && src_ready[s] && (bank_sel[s] == SEL_W'(d));
      assign q_pop[s][d]  = b_pop[d][s];
      assign b_req[d][s]  = q_nonempty[s][d];
      assign b_head[d][s] = q_head[s][d];

      xbar_pair_fifo #(.W(PW), .DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push[s][d]),
        .push_data ({src_addr[s], src_data[s]}),
        .pop       (q_pop[s][d]),
        .head      (q_head[s][d]),
        .not_empty (q_nonempty[s][d]),
        .full      (q_full[s][d])
      );
    end
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_bank
    xbar_bank_port #(.NS(NUM_SRC), .W(PW)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (b_req[d]),
      .heads       (b_head[d]),
      .out_ready   (dst_ready[d]),
      .out_valid   (dst_valid[d]),
      .out_payload (b_payload[d]),
      .out_src     (dst_src[d]),
      .pop         (b_pop[d])
    );
    assign dst_addr[d] = b_payload[d][PW-1 -: ADDR_W];
    assign dst_data[d] = b_payload[d][DATA_W-1:0];
  end

endmodule

// File: tb/core_bank_xbar_bench.sv
module core_bank_xbar_bench;
  localparam int NS = 8;
  localparam int ND = 4;
  localparam int AW = 40;
  localparam int DW = 64;
  localparam int SW = 3;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NS-1:0]          src_valid = '0;
  logic [NS-1:0][AW-1:0]  src_addr = '0;
  logic [NS-1:0][DW-1:0]  src_data = '0;
  logic [NS-1:0]          src_ready;
  logic [ND-1:0]          dst_valid;
  logic [ND-1:0][AW-1:0]  dst_addr;
  logic [ND-1:0][DW-1:0]  dst_data;
  logic [ND-1:0][SW-1:0]  dst_src;
  logic [ND-1:0]          dst_ready = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  int     lcnt [ND];
  int     lsrc [ND][64];
  longint laddr[ND][64];
  longint ldata[ND][64];

  always #4 clk = ~clk;

  core_bank_xbar u_core_bank_xbar (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_addr(src_addr), .src_data(src_data), .src_ready(src_ready),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .dst_data(dst_data), .dst_src(dst_src),
    .dst_ready(dst_ready)
  );

  // Record bank-side transfers that complete at the coming edge.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < ND; b++) begin
        if (dst_valid[b] && dst_ready[b] && lcnt[b] < 64) begin
          lsrc [b][lcnt[b]] = int'(dst_src[b]);
          laddr[b][lcnt[b]] = longint'(dst_addr[b]);
          ldata[b][lcnt[b]] = longint'(dst_data[b]);
          lcnt[b]++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic clear_log();
    for (int b = 0; b < ND; b++) lcnt[b] = 0;
  endtask

  task automatic do_reset();
    src_valid = '0;
    dst_ready = '0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    clear_log();
  endtask

  function automatic longint mk_addr(input int tag, input int bank);
    return (longint'(tag) << 8) | (longint'(bank) << 6) | 64'h15;
  endfunction

  task automatic offer(input int s, input longint a, input longint d);
    src_valid[s] = 1'b1;
    src_addr[s]  = AW'(a);
    src_data[s]  = DW'(d);
  endtask

  task automatic t_reset();
    do_reset();
    #2;
    chk("R8", "dst_valid after reset", longint'(dst_valid), 0);
    chk("R8", "src_ready after reset", longint'(src_ready), 64'hFF);
  endtask

  task automatic t_routing();
    do_reset();
    dst_ready = '1;
    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < ND; b++) begin
        offer(s, mk_addr(s * 16 + b + 1, b), 64'hD000_0000_0000_0000 | (s << 8) | b);
        #1;
        chk("R1", "src_ready on empty path", longint'(src_ready[s]), 1);
        tick();
        src_valid = '0;
        #1;
        // R1: not visible on the bank before the accepting edge; visible one cycle later
        tick();
      end
    end
    tick(3);
    for (int b = 0; b < ND; b++) begin
      chk("R1", "transfers per bank", lcnt[b], NS);
      for (int s = 0; s < NS; s++) begin
        chk("R1", "dst_src", lsrc[b][s], s);
        chk("R1", "dst_addr", laddr[b][s], mk_addr(s * 16 + b + 1, b));
        chk("R1", "dst_data", ldata[b][s], 64'hD000_0000_0000_0000 | (s << 8) | b);
      end
    end
  endtask

  task automatic t_capacity();
    do_reset();
    offer(2, mk_addr(1, 1), 64'hA1);
    #1 chk("R2", "first push ready", longint'(src_ready[2]), 1);
    chk("R1", "bank 1 idle in accept cycle", longint'(dst_valid[1]), 0);
    tick();
    offer(2, mk_addr(2, 1), 64'hA2);
    #1 chk("R2", "second push ready", longint'(src_ready[2]), 1);
    chk("R1", "bank 1 valid cycle after accept", longint'(dst_valid[1]), 1);
    tick();
    offer(2, mk_addr(3, 1), 64'hA3);
    #1 chk("R2", "third push stalled", longint'(src_ready[2]), 0);
    chk("R6", "held source", longint'(dst_src[1]), 2);
    chk("R6", "held addr", longint'(dst_addr[1]), mk_addr(1, 1));
    tick(2);
    chk("R6", "held addr after stall", longint'(dst_addr[1]), mk_addr(1, 1));
    chk("R6", "held data after stall", longint'(dst_data[1]), 64'hA1);
    chk("R2", "still stalled", longint'(src_ready[2]), 0);
    offer(2, mk_addr(4, 3), 64'hB4);
    #1 chk("R3", "other bank accepted", longint'(src_ready[2]), 1);
    tick();
    offer(2, mk_addr(3, 1), 64'hA3);
    #1 chk("R2", "full again", longint'(src_ready[2]), 0);
    dst_ready[1] = 1'b1;
    #1 chk("R7", "push with pop on full queue", longint'(src_ready[2]), 1);
    tick();
    src_valid = '0;
    tick(4);
    dst_ready = '1;
    tick(3);
    chk("R4", "bank 1 count", lcnt[1], 3);
    chk("R4", "bank 1 first", laddr[1][0], mk_addr(1, 1));
    chk("R4", "bank 1 second", laddr[1][1], mk_addr(2, 1));
    chk("R4", "bank 1 third", laddr[1][2], mk_addr(3, 1));
    chk("R4", "bank 1 third data", ldata[1][2], 64'hA3);
    chk("R3", "bank 3 request", laddr[3][0], mk_addr(4, 3));
    chk("R3", "bank 3 source", lsrc[3][0], 2);
  endtask

  task automatic t_round_robin();
    do_reset();
    offer(3, mk_addr(30, 0), 64'h3);
    offer(5, mk_addr(50, 0), 64'h5);
    tick();
    src_valid = '0;
    tick();
    chk("R5", "first winner from pointer 0", longint'(dst_src[0]), 3);
    dst_ready[0] = 1'b1;
    tick(3);
    dst_ready[0] = 1'b0;
    offer(1, mk_addr(10, 0), 64'h1);
    offer(4, mk_addr(40, 0), 64'h4);
    offer(6, mk_addr(60, 0), 64'h6);
    tick();
    src_valid = '0;
    dst_ready[0] = 1'b1;
    tick(5);
    chk("R5", "grant count", lcnt[0], 5);
    chk("R5", "grant 0", lsrc[0][0], 3);
    chk("R5", "grant 1", lsrc[0][1], 5);
    chk("R5", "grant 2 resumes after 5", lsrc[0][2], 6);
    chk("R5", "grant 3 wraps", lsrc[0][3], 1);
    chk("R5", "grant 4", lsrc[0][4], 4);
  endtask

  task automatic t_hold();
    do_reset();
    offer(4, mk_addr(44, 2), 64'h44);
    tick();
    src_valid = '0;
    tick();
    chk("R6", "offer from source 4", longint'(dst_src[2]), 4);
    offer(0, mk_addr(7, 2), 64'h7);
    tick();
    src_valid = '0;
    tick();
    chk("R6", "offer kept despite source 0", longint'(dst_src[2]), 4);
    chk("R6", "offer data kept", longint'(dst_data[2]), 64'h44);
    dst_ready[2] = 1'b1;
    tick(3);
    chk("R6", "drain count", lcnt[2], 2);
    chk("R6", "drain first", lsrc[2][0], 4);
    chk("R5", "drain second", lsrc[2][1], 0);
  endtask

  initial begin
    t_reset();
    t_routing();
    t_capacity();
    t_round_robin();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule